// File: doc/BRIEF.md
# Byte-Level Slave Protocol Engine

This block sits behind the byte interface of an I2C slave and handles a framed request/response exchange with an embedded controller. For each byte event it takes a set of status flags and the byte captured on the bus. The flags are interrupt, address-received, master-reads and end-of-transfer. In return it gives a byte to put on the bus and drives an active-low request line. The request line asks the controller to come and fetch a pending outbound message.

When the controller writes, the engine builds the frame in a local buffer. At end of transfer it checks the length against the length coded in the frame header. A frame that matches is pushed to the receive queue and a frame that does not is discarded. When the controller issues read command 0x01 and then turns the bus around, the engine streams the current outbound message byte by byte. If no message is waiting, it streams a fixed three-byte no-op frame instead. If the transfer ends before the whole message has gone out, the stream restarts from the beginning and the request line is driven low again.

All outputs are registered. They reflect an event one clock after the cycle in which `evt_valid` is high.

Top module: `sl_byte_engine`

## Requirements
- R1: An event whose flags are exactly interrupt+address-received starts a transfer from any state. The next state is command, and `addr_err` pulses if the byte differs from `own_addr`.
- R2: An event without the interrupt flag is ignored. It changes no state, buffer or position, and raises no output.
- R3: In the command state, a bare interrupt stores the byte as frame byte 0 and moves on. Any other flag set returns the engine to idle.
- R4: After the command byte, an interrupt+address-received+master-reads event starts a read only when byte 0 is 0x01. Otherwise the engine goes idle and sends 0xFF.
- R5: After the command byte, a bare interrupt stores frame byte 1 and enters the write-data state.
- R6: During a read, each interrupt+master-reads event sends the next message byte. A read past the message size sends 0xFF and returns to idle.
- R7: End of transfer during a read with bytes still unsent rewinds the stream to byte 0, keeps the read state and drives `req_n` low. With all bytes sent it returns to idle, and `tx_done` pulses for a real message.
- R8: In the write-data state, bare interrupts append bytes up to MSG_MAX and drop any beyond it. Master-reads or address-received returns the engine to idle.
- R9: End of transfer without master-reads in the write-data state pushes the frame when its length equals the coded length, and discards it otherwise. If byte0 bit 7 is 0, or bits 6:5 are 2, the coded length is byte1+2. Otherwise class 0 gives 2, class 1 gives 3 and class 3 gives 0.
- R10: `rx_xfer_done` pulses with a push whose byte0 bit 7 is 0.
- R11: `resp_valid` pulses for every interrupt event that has master-reads set and end-of-transfer clear. `resp_byte` is 0xFF unless a message byte is due.
- R12: `req_n` is low while `tx_avail` is high and no read of the message is in flight. It goes high after the interrupt+address-received+master-reads event.
- R13: With `tx_avail` low at read start, the bytes sent are 0x02, 0x07, 0x02, and completing this frame does not pulse `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A byte event is presented this cycle |
| evt_irq | input | 1 | Interrupt flag |
| evt_rcvd | input | 1 | Address-received flag |
| evt_rnw | input | 1 | Master-reads flag |
| evt_fin | input | 1 | End-of-transfer flag |
| evt_byte | input | 8 | Byte captured on the bus |
| own_addr | input | 8 | Expected address byte |
| tx_avail | input | 1 | An outbound message is waiting |
| tx_size | input | TW | Size in bytes of the outbound message |
| tx_rd_idx | output | TW | Index of the outbound byte being read |
| tx_rd_data | input | 8 | Outbound byte at `tx_rd_idx` |
| resp_valid | output | 1 | A byte is to be driven onto the bus |
| resp_byte | output | 8 | Byte to drive |
| req_n | output | 1 | Request line, low asks for a read |
| addr_err | output | 1 | Address mismatch at transfer start |
| tx_done | output | 1 | Outbound message fully sent |
| rx_push | output | 1 | Received frame accepted |
| rx_drop | output | 1 | Received frame discarded |
| rx_xfer_done | output | 1 | Accepted frame was a response |
| rx_len | output | PW | Bytes held in the receive buffer |
| rx_msg | output | MSG_MAX*8 | Receive buffer, byte 0 in the low bits |

## Verification
The bench sends write frames drawn at random across all four length classes and both event/response kinds. Each frame is sized exactly right, one short or one long, so a wrong length decoder either drops good frames or passes bad ones. Directed cases cover an oversize frame that fills the buffer, a read after a non-0x01 command (a faulty gate would stream real data), an event with no interrupt mid-frame (a faulty filter would append a byte or answer a read), a premature end (the following read would give byte 2 instead of byte 0, and the request line would stay high), the no-op frame, and reading past the end.

// File: rtl/sl_proto_pkg.sv
package sl_proto_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_LEN  = 3'd2,
    ST_TXS  = 3'd3,
    ST_RXD  = 3'd4
  } eng_state_t;

  typedef struct packed {
    logic irq;
    logic rcvd;
    logic rnw;
    logic fin;
  } evt_flags_t;

  localparam evt_flags_t F_START = '{irq: 1'b1, rcvd: 1'b1, rnw: 1'b0, fin: 1'b0};
  localparam evt_flags_t F_BARE  = '{irq: 1'b1, rcvd: 1'b0, rnw: 1'b0, fin: 1'b0};
  localparam evt_flags_t F_RDGO  = '{irq: 1'b1, rcvd: 1'b1, rnw: 1'b1, fin: 1'b0};

  localparam logic [7:0] READ_CMD  = 8'h01;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // Expected total length of a received frame from its first two bytes.
  function automatic logic [8:0] frame_len(input logic [7:0] b0, input logic [7:0] b1);
    logic [8:0] len;
    if (!b0[7] || b0[6:5] == 2'd2) begin
      len = {1'b0, b1} + 9'd2;
    end else begin
      case (b0[6:5])
        2'd0:    len = 9'd2;
        2'd1:    len = 9'd3;
        default: len = 9'd0;
      endcase
    end
    return len;
  endfunction

  // Filler frame streamed when nothing is queued for transmit.
  function automatic logic [7:0] noop_byte(input int unsigned idx);
    logic [7:0] b;
    case (idx)
      0, 2:    b = 8'h02;
      1:       b = 8'h07;
      default: b = IDLE_BYTE;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sl_rx_frame.sv
module sl_rx_frame
  import sl_proto_pkg::*;
#(
  parameter int MSG_MAX = 32,
  parameter int PW      = $clog2(MSG_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 first_en,
  input  logic                 app_en,
  input  logic [7:0]           wr_byte,
  output logic [PW-1:0]        pos,
  output logic [MSG_MAX*8-1:0] msg_flat,
  output logic [7:0]           head,
  output logic                 len_ok,
  output logic                 is_event
);

  logic [PW-1:0] pos_q, pos_d;
  logic          room;
  logic [8:0]    want_len;

  assign room = pos_q < PW'(MSG_MAX);

  always_comb begin
    pos_d = pos_q;
    if (first_en) begin
      pos_d = PW'(1);
    end else if (app_en && room) begin
      pos_d = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  for (genvar g = 0; g < MSG_MAX; g++) begin : g_cell
    logic [7:0] cell_q;
    logic       cell_we;
    if (g == 0) begin : g_head
      assign cell_we = first_en;
    end else begin : g_body
      assign cell_we = app_en && room && (pos_q == PW'(g));
    end
    always_ff @(posedge clk) begin
      if (cell_we) begin
        cell_q <= wr_byte;
      end
    end
    assign msg_flat[g*8 +: 8] = cell_q;
  end

  assign head     = msg_flat[7:0];
  assign want_len = frame_len(msg_flat[7:0], msg_flat[15:8]);
  assign len_ok   = (32'(want_len) == 32'(pos_q));
  assign is_event = msg_flat[7];
  assign pos      = pos_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PW'(MSG_MAX));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == PW'(MSG_MAX) && app_en && !first_en) |=> (pos_q == PW'(MSG_MAX)));

endmodule

// File: rtl/sl_tx_stream.sv
module sl_tx_stream
  import sl_proto_pkg::*;
#(
  parameter int TX_MAX = 32,
  parameter int TW     = $clog2(TX_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          restart,
  input  logic          adv,
  input  logic          tx_avail,
  input  logic [TW-1:0] tx_size,
  input  logic [7:0]    tx_rd_data,
  output logic [TW-1:0] rd_idx,
  output logic [7:0]    cur_byte,
  output logic          has_more,
  output logic          at_end,
  output logic          is_real
);

  localparam logic [TW-1:0] NOOP_LEN = TW'(3);

  logic [TW-1:0] pos_q, pos_d, size_q, size_d;
  logic          real_q, real_d;
  logic          use_noop;

  always_comb begin
    pos_d  = pos_q;
    size_d = size_q;
    real_d = real_q;
    if (load) begin
      pos_d  = TW'(1);
      size_d = tx_avail ? tx_size : NOOP_LEN;
      real_d = tx_avail;
    end else if (restart) begin
      pos_d = '0;
    end else if (adv) begin
      pos_d = pos_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      size_q <= '0;
      real_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      size_q <= size_d;
      real_q <= real_d;
    end
  end

  assign rd_idx   = load ? '0 : pos_q;
  assign use_noop = load ? !tx_avail : !real_q;
  assign cur_byte = use_noop ? noop_byte(32'(rd_idx)) : tx_rd_data;
  assign has_more = pos_q < size_q;
  assign at_end   = pos_q == size_q;
  assign is_real  = real_q;

  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) |-> (pos_q <= size_q));

  assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !load) |=> (pos_q == '0));

endmodule

// File: rtl/sl_ctrl_fsm.sv
module sl_ctrl_fsm
  import sl_proto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  evt_flags_t flags,
  input  logic [7:0] evt_byte,
  input  logic [7:0] own_addr,
  input  logic [7:0] cmd_byte,
  input  logic       len_ok,
  input  logic       is_event,
  input  logic       tx_avail,
  input  logic [7:0] cur_byte,
  input  logic       has_more,
  input  logic       at_end,
  input  logic       is_real,
  output logic       first_en,
  output logic       app_en,
  output logic       load,
  output logic       restart,
  output logic       adv,
  output logic       resp_valid,
  output logic [7:0] resp_byte,
  output logic       req_n,
  output logic       addr_err,
  output logic       rx_push,
  output logic       rx_drop,
  output logic       rx_xfer_done,
  output logic       tx_done
);

  eng_state_t state_q, state_d;
  logic       act;
  logic       fly_q, fly_d;
  logic [7:0] send;
  logic       rv_d, push_d, drop_d, xd_d, td_d, ae_d;

  assign act = evt_valid && flags.irq;

  always_comb begin
    state_d  = state_q;
    fly_d    = fly_q;
    first_en = 1'b0;
    app_en   = 1'b0;
    load     = 1'b0;
    restart  = 1'b0;
    adv      = 1'b0;
    send     = IDLE_BYTE;
    push_d   = 1'b0;
    drop_d   = 1'b0;
    xd_d     = 1'b0;
    td_d     = 1'b0;
    ae_d     = 1'b0;
    if (act) begin
      case ((flags == F_START) ? ST_IDLE : state_q)
        ST_IDLE: ;
        ST_CMD: begin
          if (flags == F_BARE) begin
            first_en = 1'b1;
            state_d  = ST_LEN;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_LEN: begin
          if (flags == F_RDGO) begin
            if (cmd_byte == READ_CMD) begin
              load    = 1'b1;
              send    = cur_byte;
              state_d = ST_TXS;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (flags == F_BARE) begin
            app_en  = 1'b1;
            state_d = ST_RXD;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_TXS: begin
          if (flags.fin) begin
            if (at_end) begin
              state_d = ST_IDLE;
              td_d    = is_real;
              fly_d   = 1'b0;
            end else begin
              restart = 1'b1;
              fly_d   = 1'b0;
            end
          end else if (!flags.rnw || flags.rcvd) begin
            state_d = ST_IDLE;
          end else if (has_more) begin
            adv  = 1'b1;
            send = cur_byte;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_RXD: begin
          if (flags.fin && !flags.rnw) begin
            state_d = ST_IDLE;
            if (len_ok) begin
              push_d = 1'b1;
              xd_d   = !is_event;
            end else begin
              drop_d = 1'b1;
            end
          end else if (flags.rnw || flags.rcvd) begin
            state_d = ST_IDLE;
          end else begin
            app_en = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (flags.rcvd && !flags.rnw) begin
        state_d = ST_CMD;
        ae_d    = (evt_byte != own_addr);
      end
      if (flags == F_RDGO) begin
        fly_d = 1'b1;
      end
    end
    rv_d = act && flags.rnw && !flags.fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fly_q        <= 1'b0;
      resp_valid   <= 1'b0;
      req_n        <= 1'b1;
      addr_err     <= 1'b0;
      rx_push      <= 1'b0;
      rx_drop      <= 1'b0;
      rx_xfer_done <= 1'b0;
      tx_done      <= 1'b0;
    end else begin
      state_q      <= state_d;
      fly_q        <= fly_d;
      resp_valid   <= rv_d;
      req_n        <= !(tx_avail && !fly_d);
      addr_err     <= ae_d;
      rx_push      <= push_d;
      rx_drop      <= drop_d;
      rx_xfer_done <= xd_d;
      tx_done      <= td_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_byte <= IDLE_BYTE;
    end else if (rv_d) begin
      resp_byte <= send;
    end
  end

  assert_start_to_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && flags.irq && flags.rcvd && !flags.rnw) |=> (state_q == ST_CMD));

  assert_no_irq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !flags.irq) |=> (state_q == $past(state_q) && !resp_valid));

  assert_read_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && state_q == ST_LEN && flags == F_RDGO && cmd_byte != READ_CMD)
      |=> (state_q == ST_IDLE));

  assert_push_drop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_push, rx_drop}));

  assert_done_needs_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer_done |-> rx_push);

  assert_fin_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && flags.irq && flags.fin) |=> !resp_valid);

endmodule

// File: rtl/sl_byte_engine.sv
module sl_byte_engine
  import sl_proto_pkg::*;
#(
  parameter int MSG_MAX = 32,
  parameter int TX_MAX  = 32,
  parameter int PW      = $clog2(MSG_MAX + 1),
  parameter int TW      = $clog2(TX_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic                 evt_irq,
  input  logic                 evt_rcvd,
  input  logic                 evt_rnw,
  input  logic                 evt_fin,
  input  logic [7:0]           evt_byte,
  input  logic [7:0]           own_addr,
  input  logic                 tx_avail,
  input  logic [TW-1:0]        tx_size,
  output logic [TW-1:0]        tx_rd_idx,
  input  logic [7:0]           tx_rd_data,
  output logic                 resp_valid,
  output logic [7:0]           resp_byte,
  output logic                 req_n,
  output logic                 addr_err,
  output logic                 tx_done,
  output logic                 rx_push,
  output logic                 rx_drop,
  output logic                 rx_xfer_done,
  output logic [PW-1:0]        rx_len,
  output logic [MSG_MAX*8-1:0] rx_msg
);

  evt_flags_t flags;
  logic       first_en, app_en, load, restart, adv;
  logic [7:0] head, cur_byte;
  logic       len_ok, is_event, has_more, at_end, is_real;

  assign flags = '{irq: evt_irq, rcvd: evt_rcvd, rnw: evt_rnw, fin: evt_fin};

  sl_rx_frame #(.MSG_MAX(MSG_MAX), .PW(PW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .first_en (first_en),
    .app_en   (app_en),
    .wr_byte  (evt_byte),
    .pos      (rx_len),
    .msg_flat (rx_msg),
    .head     (head),
    .len_ok   (len_ok),
    .is_event (is_event)
  );

  sl_tx_stream #(.TX_MAX(TX_MAX), .TW(TW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .restart    (restart),
    .adv        (adv),
    .tx_avail   (tx_avail),
    .tx_size    (tx_size),
    .tx_rd_data (tx_rd_data),
    .rd_idx     (tx_rd_idx),
    .cur_byte   (cur_byte),
    .has_more   (has_more),
    .at_end     (at_end),
    .is_real    (is_real)
  );

  sl_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_valid    (evt_valid),
    .flags        (flags),
    .evt_byte     (evt_byte),
    .own_addr     (own_addr),
    .cmd_byte     (head),
    .len_ok       (len_ok),
    .is_event     (is_event),
    .tx_avail     (tx_avail),
    .cur_byte     (cur_byte),
    .has_more     (has_more),
    .at_end       (at_end),
    .is_real      (is_real),
    .first_en     (first_en),
    .app_en       (app_en),
    .load         (load),
    .restart      (restart),
    .adv          (adv),
    .resp_valid   (resp_valid),
    .resp_byte    (resp_byte),
    .req_n        (req_n),
    .addr_err     (addr_err),
    .rx_push      (rx_push),
    .rx_drop      (rx_drop),
    .rx_xfer_done (rx_xfer_done),
    .tx_done      (tx_done)
  );

endmodule

// File: tb/tb_sl_byte_engine.sv
module tb_sl_byte_engine;

  localparam int CLK_PERIOD = 10;
  localparam int MSG_MAX    = 32;
  localparam int TX_MAX     = 32;
  localparam int PW         = $clog2(MSG_MAX + 1);
  localparam int TW         = $clog2(TX_MAX + 1);
  localparam logic [7:0] ADDR = 8'h8A;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 evt_valid, evt_irq, evt_rcvd, evt_rnw, evt_fin;
  logic [7:0]           evt_byte;
  logic                 tx_avail;
  logic [TW-1:0]        tx_size;
  logic [TW-1:0]        tx_rd_idx;
  logic [7:0]           tx_rd_data;
  logic                 resp_valid, req_n, addr_err, tx_done;
  logic [7:0]           resp_byte;
  logic                 rx_push, rx_drop, rx_xfer_done;
  logic [PW-1:0]        rx_len;
  logic [MSG_MAX*8-1:0] rx_msg;

  logic [7:0] tx_mem [64];
  logic [7:0] fr [48];
  int checks = 0;
  int errors = 0;

  assign tx_rd_data = tx_mem[tx_rd_idx];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sl_byte_engine #(.MSG_MAX(MSG_MAX), .TX_MAX(TX_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_irq(evt_irq),
    .evt_rcvd(evt_rcvd), .evt_rnw(evt_rnw), .evt_fin(evt_fin),
    .evt_byte(evt_byte), .own_addr(ADDR), .tx_avail(tx_avail),
    .tx_size(tx_size), .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data),
    .resp_valid(resp_valid), .resp_byte(resp_byte), .req_n(req_n),
    .addr_err(addr_err), .tx_done(tx_done), .rx_push(rx_push),
    .rx_drop(rx_drop), .rx_xfer_done(rx_xfer_done), .rx_len(rx_len),
    .rx_msg(rx_msg)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] b0, input logic [7:0] b1);
    if (b0[7] == 1'b0) return int'(b1) + 2;
    if (b0[6:5] == 2'b10) return int'(b1) + 2;
    if (b0[6:5] == 2'b00) return 2;
    if (b0[6:5] == 2'b01) return 3;
    return 0;
  endfunction

  task automatic ev(input logic i, input logic r, input logic w, input logic f,
                    input logic [7:0] b);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_irq = i; evt_rcvd = r; evt_rnw = w; evt_fin = f; evt_byte = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_reset();
    evt_valid = 1'b0; evt_irq = 1'b0; evt_rcvd = 1'b0; evt_rnw = 1'b0;
    evt_fin = 1'b0; evt_byte = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Sends a complete write frame of n bytes from fr[] and checks the outcome.
  task automatic wr_and_check(input int n, input string tag);
    int stored, want;
    bit push_exp, same;
    ev(1, 1, 0, 0, ADDR);
    for (int i = 0; i < n; i++) ev(1, 0, 0, 0, fr[i]);
    ev(1, 0, 0, 1, 8'h00);
    stored   = (n < MSG_MAX) ? n : MSG_MAX;
    want     = exp_len(fr[0], fr[1]);
    push_exp = (stored == want);
    chk({"R9 push ", tag}, int'(rx_push), int'(push_exp));
    chk({"R9 drop ", tag}, int'(rx_drop), int'(!push_exp));
    chk({"R8 len ", tag}, int'(rx_len), stored);
    chk({"R10 xfer_done ", tag}, int'(rx_xfer_done), int'(push_exp && !fr[0][7]));
    same = 1'b1;
    for (int i = 0; i < stored; i++) if (rx_msg[i*8 +: 8] != fr[i]) same = 1'b0;
    chk({"R8 content ", tag}, int'(same), 1);
  endtask

  // Reads size bytes of the queued message and ends the transfer.
  task automatic rd_and_check(input int size, input string tag);
    bit ok;
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h01);
    ev(1, 1, 1, 0, 8'h00);
    ok = resp_valid && resp_byte == tx_mem[0];
    chk({"R6 first byte ", tag}, int'(resp_byte), int'(tx_mem[0]));
    chk({"R12 req released ", tag}, int'(req_n), 1);
    for (int i = 1; i < size; i++) begin
      ev(1, 0, 1, 0, 8'h00);
      if (!(resp_valid && resp_byte == tx_mem[i])) ok = 1'b0;
    end
    chk({"R6 stream ", tag}, int'(ok), 1);
    ev(1, 0, 1, 1, 8'h00);
    chk({"R11 no byte at end ", tag}, int'(resp_valid), 0);
    chk({"R7 tx_done ", tag}, int'(tx_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed, n, want, sz;
    logic [1:0] cls;
    logic evb;
    seed = int'($urandom(32'd24681));
    tx_avail = 1'b0;
    tx_size  = '0;
    for (int i = 0; i < 64; i++) tx_mem[i] = 8'(i * 7 + 3);
    do_reset();

    // Reset state
    chk("R12 reset req_n", int'(req_n), 1);
    chk("R11 reset resp_valid", int'(resp_valid), 0);
    chk("R9 reset push", int'(rx_push | rx_drop | tx_done | addr_err), 0);

    // R1: address check
    ev(1, 1, 0, 0, 8'h55);
    chk("R1 addr mismatch", int'(addr_err), 1);
    ev(1, 1, 0, 0, ADDR);
    chk("R1 addr match", int'(addr_err), 0);

    // R2: events without interrupt ignored mid-frame
    ev(1, 0, 0, 0, 8'h80);
    ev(1, 0, 0, 0, 8'h11);
    ev(0, 0, 0, 0, 8'h33);
    ev(0, 0, 1, 0, 8'h00);
    chk("R2 no response", int'(resp_valid), 0);
    ev(0, 0, 0, 1, 8'h00);
    chk("R2 no completion", int'(rx_push | rx_drop), 0);
    ev(1, 0, 0, 1, 8'h00);
    chk("R2 push after ignored", int'(rx_push), 1);
    chk("R2 len unchanged", int'(rx_len), 2);
    chk("R10 event no xfer_done", int'(rx_xfer_done), 0);

    // R3: wrong flags in command state go idle
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 1, 0, 8'h00);
    ev(1, 0, 0, 0, 8'h80);
    ev(1, 0, 0, 0, 8'h00);
    ev(1, 0, 0, 1, 8'h00);
    chk("R3 idle after bad cmd flags", int'(rx_push | rx_drop), 0);

    // R5/R9/R10: directed response frame
    fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'hA1; fr[3] = 8'hB2;
    wr_and_check(4, "resp");
    // R9 class 3 always dropped
    fr[0] = 8'hE3; fr[1] = 8'h00;
    wr_and_check(2, "class3");
    // R8 overflow
    fr[0] = 8'h00; fr[1] = 8'd40;
    for (int i = 2; i < 34; i++) fr[i] = 8'(i + 100);
    wr_and_check(34, "overflow");

    // R8: read flag during write data goes idle
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h83);
    ev(1, 0, 0, 0, 8'h44);
    ev(1, 0, 1, 0, 8'h00);
    chk("R11 default byte", int'(resp_byte), 8'hFF);
    ev(1, 0, 0, 1, 8'h00);
    chk("R8 error no completion", int'(rx_push | rx_drop), 0);

    // Random write frames
    for (int t = 0; t < 40; t++) begin
      cls = 2'($urandom % 4);
      evb = 1'($urandom % 2);
      fr[0] = {evb, cls, 5'($urandom)};
      fr[1] = 8'($urandom % 12);
      for (int i = 2; i < 48; i++) fr[i] = 8'($urandom);
      want = exp_len(fr[0], fr[1]);
      if (want < 2) n = 2 + int'($urandom % 3);
      else n = want + int'($urandom % 3) - 1;
      if (n < 2) n = 2;
      wr_and_check(n, "random");
    end

    // R12/R6/R7: real message, directed
    tx_size = TW'(4); tx_avail = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 req asserted", int'(req_n), 0);
    rd_and_check(4, "directed");
    tx_avail = 1'b0;

    // R7: premature end rewinds and re-requests
    tx_avail = 1'b1; tx_size = TW'(4);
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h01);
    ev(1, 1, 1, 0, 8'h00);
    ev(1, 0, 1, 0, 8'h00);
    ev(1, 0, 1, 1, 8'h00);
    chk("R7 no tx_done early", int'(tx_done), 0);
    chk("R7 req re-asserted", int'(req_n), 0);
    ev(1, 0, 1, 0, 8'h00);
    chk("R7 rewind to byte 0", int'(resp_byte), int'(tx_mem[0]));
    for (int i = 1; i < 4; i++) ev(1, 0, 1, 0, 8'h00);
    chk("R7 last byte after rewind", int'(resp_byte), int'(tx_mem[3]));
    ev(1, 0, 1, 1, 8'h00);
    chk("R7 done after rewind", int'(tx_done), 1);
    tx_avail = 1'b0;

    // Random reads
    for (int t = 0; t < 10; t++) begin
      sz = 1 + int'($urandom % 8);
      for (int i = 0; i < 64; i++) tx_mem[i] = 8'($urandom);
      tx_size = TW'(sz); tx_avail = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 req random", int'(req_n), 0);
      rd_and_check(sz, "random");
      tx_avail = 1'b0;
    end

    // R13: no-op frame
    @(negedge clk);
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h01);
    ev(1, 1, 1, 0, 8'h00);
    chk("R13 noop byte0", int'(resp_byte), 8'h02);
    ev(1, 0, 1, 0, 8'h00);
    chk("R13 noop byte1", int'(resp_byte), 8'h07);
    ev(1, 0, 1, 0, 8'h00);
    chk("R13 noop byte2", int'(resp_byte), 8'h02);
    ev(1, 0, 1, 1, 8'h00);
    chk("R13 no tx_done for noop", int'(tx_done), 0);

    // R6: read past the end
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h01);
    ev(1, 1, 1, 0, 8'h00);
    ev(1, 0, 1, 0, 8'h00);
    ev(1, 0, 1, 0, 8'h00);
    ev(1, 0, 1, 0, 8'h00);
    chk("R6 underflow valid", int'(resp_valid), 1);
    chk("R6 underflow byte", int'(resp_byte), 8'hFF);
    ev(1, 0, 1, 1, 8'h00);
    chk("R6 idle after underflow", int'(tx_done), 0);

    // R4: read refused after non-0x01 command
    ev(1, 1, 0, 0, ADDR);
    ev(1, 0, 0, 0, 8'h05);
    ev(1, 1, 1, 0, 8'h00);
    chk("R4 refused valid", int'(resp_valid), 1);
    chk("R4 refused byte", int'(resp_byte), 8'hFF);
    ev(1, 0, 1, 0, 8'h00);
    chk("R4 stays idle", int'(resp_byte), 8'hFF);

    summary();
    $finish;
  end

endmodule